// File: doc/BRIEF.md
# Rounding Shift-Right Unit

This block shifts a 64-bit operand right by a variable amount and rounds the result to nearest. It does this by adding back the last bit that the shift discards. A mode input selects a logical shift for unsigned data or an arithmetic shift for signed data. Each region of shift amount has a defined result: zero, inside the word, exactly the word width, and beyond it. A plain barrel shifter would leave the last two regions undefined, or would wrap the shift amount.

The unit is a datapath fed by a small decoder. The decoder sorts the shift amount into its region and drives one strobe for that region. An optional output register, chosen by a parameter and on by default, adds one cycle of latency. With the register in place, the result for the inputs present at a rising clock edge appears at the output after that edge. Active-low reset clears the register.

Top module: `round_shr_unit`

## Requirements
- R1: In unsigned mode (`signedMode`=0), for a shift of 1 to 63 the result is the operand shifted right logically by `shAmt`, plus operand bit `shAmt`-1.
- R2: In signed mode (`signedMode`=1), for a shift of 1 to 63 the operand is shifted right arithmetically, with the sign copied into the vacated upper bits. Operand bit `shAmt`-1 is then added.
- R3: A shift amount of 0 returns the operand unchanged in both modes, with no rounding increment.
- R4: In unsigned mode, a shift of exactly 64 returns operand bit 63 in bit 0, with all other bits zero.
- R5: In unsigned mode, any shift from 65 to 255 returns zero.
- R6: In signed mode, any shift from 64 to 255 returns zero.
- R7: The rounding addition is modulo 2^64 and has no carry or flag output. In signed mode an all-ones operand therefore gives zero for every shift from 1 to 63.
- R8: With the output register enabled (the default), `result` shows the value for the inputs sampled at a rising edge of `clk` after that edge. While `rstN` is low, `result` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rstN | input | 1 | Active-low synchronous reset of the output register |
| operand | input | 64 | Value to be shifted |
| shAmt | input | 8 | Right-shift amount, 0 to 255 |
| signedMode | input | 1 | 1 selects an arithmetic shift, 0 a logical shift |
| result | output | 64 | Rounded shift result |

## Verification
The assertions check on every cycle the results of the edge regions: the pass-through at a shift of zero, the single bit 63 at an unsigned shift of 64, and the zero output beyond the word in both modes. They also check that reset holds the output at zero. The rounded value inside the word depends on the full shifter and adder, so only the bench's scenarios can show it. These scenarios sweep every shift amount in both modes and use all-ones, most-negative and mixed operands. The wrap-around of the signed all-ones case is also shown only by the bench, as is the one-cycle latency.

// File: rtl/round_shr_pkg.sv
package round_shr_pkg;
  // One-hot region strobes from control to datapath; all low means "force zero".
  typedef struct packed {
    logic passThru;    // shift of zero
    logic doRound;     // shift inside the word
    logic topBitOnly;  // unsigned shift of exactly the width
    logic signedMode;  // arithmetic shift select
  } shiftCtrl_t;
endpackage

// File: rtl/round_shr_ctrl.sv
module round_shr_ctrl
  import round_shr_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int SH_W   = 8
) (
  input  logic [SH_W-1:0] shAmt,
  input  logic            signedMode,
  output shiftCtrl_t      ctrl
);
  localparam logic [SH_W-1:0] WIDTH_AMT = SH_W'(DATA_W);

  logic isZero;
  logic belowWidth;
  logic atWidth;

  always_comb begin
    isZero     = (shAmt == '0);
    belowWidth = (shAmt < WIDTH_AMT);
    atWidth    = (shAmt == WIDTH_AMT);
    ctrl.passThru   = isZero;
    ctrl.doRound    = belowWidth && !isZero;
    ctrl.topBitOnly = atWidth && !signedMode;
    ctrl.signedMode = signedMode;
  end
endmodule

// File: rtl/round_shr_dp.sv
module round_shr_dp
  import round_shr_pkg::*;
#(
  parameter int DATA_W = 64,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] operand,
  input  logic [IDX_W-1:0]  amt,
  input  shiftCtrl_t        ctrl,
  output logic [DATA_W-1:0] resNow
);
  logic [IDX_W-1:0]  roundIdx;
  logic [DATA_W-1:0] logicalShift;
  logic [DATA_W-1:0] arithShift;
  logic [DATA_W-1:0] shifted;
  logic              roundBit;

  always_comb begin
    roundIdx     = amt - IDX_W'(1);
    logicalShift = operand >> amt;
    arithShift   = DATA_W'($signed(operand) >>> amt);
    shifted      = ctrl.signedMode ? arithShift : logicalShift;
    roundBit     = operand[roundIdx];
    if (ctrl.passThru)
      resNow = operand;
    else if (ctrl.doRound)
      resNow = shifted + DATA_W'(roundBit);
    else if (ctrl.topBitOnly)
      resNow = DATA_W'(operand[DATA_W-1]);
    else
      resNow = '0;
  end
endmodule

// File: rtl/round_shr_unit.sv
module round_shr_unit
  import round_shr_pkg::*;
#(
  parameter int DATA_W    = 64,
  parameter int SH_W      = 8,
  parameter bit OUT_STAGE = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] operand,
  input  logic [SH_W-1:0]   shAmt,
  input  logic              signedMode,
  output logic [DATA_W-1:0] result
);
  localparam int IDX_W = $clog2(DATA_W);
  localparam logic [SH_W-1:0] WIDTH_AMT = SH_W'(DATA_W);

  shiftCtrl_t        ctrl;
  logic [DATA_W-1:0] resNow;

  round_shr_ctrl #(.DATA_W(DATA_W), .SH_W(SH_W)) uCtrl (
    .shAmt(shAmt), .signedMode(signedMode), .ctrl(ctrl));

  round_shr_dp #(.DATA_W(DATA_W)) uDp (
    .operand(operand), .amt(shAmt[IDX_W-1:0]), .ctrl(ctrl), .resNow(resNow));

  generate
    if (OUT_STAGE) begin : gReg
      logic [DATA_W-1:0] resQ;
      always_ff @(posedge clk) begin
        if (!rstN) resQ <= '0;
        else       resQ <= resNow;
      end
      assign result = resQ;

      // R3
      zero_shift_chk: assert property (@(posedge clk) disable iff (!rstN)
        (shAmt == '0) |=> (result == $past(operand)));
      // R4
      width_shift_chk: assert property (@(posedge clk) disable iff (!rstN)
        (!signedMode && shAmt == WIDTH_AMT) |=>
          (result == DATA_W'($past(operand[DATA_W-1]))));
      // R5
      beyond_unsigned_chk: assert property (@(posedge clk) disable iff (!rstN)
        (!signedMode && shAmt > WIDTH_AMT) |=> (result == '0));
      // R6
      beyond_signed_chk: assert property (@(posedge clk) disable iff (!rstN)
        (signedMode && shAmt >= WIDTH_AMT) |=> (result == '0));
      // R8
      reset_clear_chk: assert property (@(posedge clk)
        !rstN |=> (result == '0));
    end else begin : gComb
      assign result = resNow;
    end
  endgenerate
endmodule

// File: tb/sim_round_shr_unit.sv
`timescale 1ns/1ps
module sim_round_shr_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [63:0] operand = '0;
  logic [7:0]  shAmt = '0;
  logic        signedMode = 1'b0;
  logic [63:0] result;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  round_shr_unit u0 (.clk(clk), .rstN(rstN), .operand(operand),
    .shAmt(shAmt), .signedMode(signedMode), .result(result));

  function automatic logic [63:0] refModel(logic [63:0] op, int sh, bit sgn);
    logic [63:0] t;
    if (sh == 0) return op;
    if (sh < 64) begin
      if (sgn) t = $signed(op) >>> sh;
      else     t = op >> sh;
      return t + {63'b0, op[sh-1]};
    end
    if (sh == 64 && !sgn) return {63'b0, op[63]};
    return '0;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive at a falling edge, let one rising edge register it, sample at next falling edge.
  task automatic apply(string req, logic [63:0] op, int sh, bit sgn, logic [63:0] exp);
    @(negedge clk);
    operand = op; shAmt = 8'(sh); signedMode = sgn;
    @(negedge clk);
    check(req, result, exp);
  endtask

  task automatic testReset();
    operand = '1; shAmt = 8'd3; signedMode = 1'b0;
    repeat (2) @(negedge clk);
    check("R8 reset", result, 64'h0);
    rstN = 1'b1;
  endtask

  task automatic testZeroShift();
    apply("R3 unsigned", 64'h8000_0000_0000_0001, 0, 1'b0, 64'h8000_0000_0000_0001);
    apply("R3 signed", 64'hFFFF_FFFF_FFFF_FFFF, 0, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF);
  endtask

  task automatic testUnsignedMid();
    apply("R1 round up", 64'h0000_0000_0000_0007, 1, 1'b0, 64'h4);
    apply("R1 round down", 64'h0000_0000_0000_0005, 2, 1'b0, 64'h1);
    apply("R1 ones sh63", 64'hFFFF_FFFF_FFFF_FFFF, 63, 1'b0, 64'h2);
    apply("R1 ones sh1", 64'hFFFF_FFFF_FFFF_FFFF, 1, 1'b0, 64'h8000_0000_0000_0000);
  endtask

  task automatic testSignedMid();
    apply("R2 min sh1", 64'h8000_0000_0000_0000, 1, 1'b1, 64'hC000_0000_0000_0000);
    apply("R2 min sh63", 64'h8000_0000_0000_0000, 63, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF);
    apply("R2 neg round", 64'hFFFF_FFFF_FFFF_FFFB, 1, 1'b1, 64'hFFFF_FFFF_FFFF_FFFE);
    apply("R7 ones sh1", 64'hFFFF_FFFF_FFFF_FFFF, 1, 1'b1, 64'h0);
    apply("R7 ones sh40", 64'hFFFF_FFFF_FFFF_FFFF, 40, 1'b1, 64'h0);
  endtask

  task automatic testEdges();
    apply("R4 top set", 64'h8000_0000_0000_0000, 64, 1'b0, 64'h1);
    apply("R4 top clear", 64'h7FFF_FFFF_FFFF_FFFF, 64, 1'b0, 64'h0);
    apply("R5 sh65", 64'hFFFF_FFFF_FFFF_FFFF, 65, 1'b0, 64'h0);
    apply("R5 sh255", 64'hFFFF_FFFF_FFFF_FFFF, 255, 1'b0, 64'h0);
    apply("R6 sh64", 64'h8000_0000_0000_0000, 64, 1'b1, 64'h0);
    apply("R6 sh200", 64'hFFFF_FFFF_FFFF_FFFF, 200, 1'b1, 64'h0);
  endtask

  task automatic testSweep(logic [63:0] op);
    for (int sg = 0; sg < 2; sg++) begin
      for (int sh = 0; sh < 256; sh++) begin
        // R1 R2 R3 R4 R5 R6 across every region
        apply(sg ? "R2 sweep" : "R1 sweep", op, sh, sg[0], refModel(op, sh, sg[0]));
      end
    end
  endtask

  task automatic testLatency();
    @(negedge clk);
    operand = 64'h0000_0000_0000_00F0; shAmt = 8'd4; signedMode = 1'b0;
    @(posedge clk); #1;
    check("R8 after edge", result, 64'hF);
    operand = 64'h0000_0000_0000_0100;
    #2;
    check("R8 held", result, 64'hF);
    @(negedge clk);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    testReset();
    testZeroShift();
    testUnsignedMid();
    testSignedMid();
    testEdges();
    testLatency();
    testSweep(64'hFFFF_FFFF_FFFF_FFFF);
    testSweep(64'h8000_0000_0000_0000);
    testSweep(64'hA5C3_0F96_5A3C_F069);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule